// File: doc/BRIEF.md
# Half-Bridge Gate Control with Fault Priority

This block is the digital control core of a protected half-bridge driver. From a direction bit and an enable bit (low = inhibit), it decides which power switch conducts. It produces high-side and low-side gate enables, an error flag, a current-sense-mode flag and a request to force the fastest slew rate. Supply overvoltage, supply undervoltage and overtemperature arrive as comparator flags that are already digitized and registered. The analog sensing, the current measurement and the gate drivers are outside the block.

Faults resolve in a fixed order. Overvoltage wins over everything else and turns the high side on. Undervoltage comes next and turns both switches off without raising the error flag. Overtemperature comes last and turns both switches off. Overtemperature is held in a latch, which clears only after a long enough low pulse on the enable input while the die has cooled. Every change from one switch to the other passes through a dead interval of clock cycles, and the slew setting picks its length.

Top module: `hb_gate_ctrl`

## Requirements
- R1: After reset, and whenever `inh_i` is low with no fault active, both gate enables, `err_o` and `sense_mode_o` are 0.
- R2: With `inh_i` high and no fault, `dir_i` = 1 drives only `hs_en_o` and `dir_i` = 0 drives only `ls_en_o`. `err_o` stays 0.
- R3: Overvoltage takes priority over every other input and fault. While it is active, `ls_en_o` is 0, `hs_en_o` is 1 once the dead interval has passed, and `err_o` is 1.
- R4: Undervoltage without overvoltage turns both gates off and leaves `err_o` at 0, even when overtemperature is latched.
- R5: A high cycle on `ot_i` latches an overtemperature state. That state turns both gates off and holds after `ot_i` falls. `err_o` equals `inh_i` while the state is held.
- R6: The overtemperature latch clears only at the RST_CYC-th consecutive clock edge with `inh_i` low, and only if `ot_cool_i` and `!ot_i` hold at that edge. A shorter low pulse, or a pulse without `ot_cool_i`, leaves the latch set.
- R7: `fast_slew_o` is 1 exactly while any fault state (overvoltage, undervoltage or latched overtemperature) is active. During that time the dead interval uses the shortest setting (`slew_sel_i` = 0).
- R8: `hs_en_o` and `ls_en_o` are never 1 in the same cycle, including while faults start and end.
- R9: When conduction moves from one switch to the other, both gates are low for exactly DT_BASE*(sel+1)+1 cycles, where sel is the effective slew setting.
- R10: `sense_mode_o` is 1 only while the high side conducts in normal mode. It is 0 with the low side on, in standby and in every fault state.
- R11: Overvoltage and undervoltage each become active at an edge where their `*_enter_i` flag is high. They become inactive only at an edge where their `*_exit_i` flag is high and the enter flag is low. An enter flag wins when both flags are high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | Direction: 1 selects high side, 0 selects low side |
| inh_i | input | 1 | Enable; low puts the bridge in standby |
| ov_enter_i | input | 1 | Supply above overvoltage trip level |
| ov_exit_i | input | 1 | Supply below overvoltage release level |
| uv_enter_i | input | 1 | Supply below undervoltage trip level |
| uv_exit_i | input | 1 | Supply above undervoltage release level |
| ot_i | input | 1 | Die overtemperature detected |
| ot_cool_i | input | 1 | Die cooled by the thermal hysteresis |
| slew_sel_i | input | SLEW_W | Slew setting, selects dead interval |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| err_o | output | 1 | Error flag |
| sense_mode_o | output | 1 | Status output in current-sense mode |
| fast_slew_o | output | 1 | Force fastest slew rate |

## Verification
The hardest state to reach is the edge of the overtemperature clear. The latch must survive an enable-low pulse one edge short of RST_CYC, and it must also survive a pulse long enough that arrives while the die is still hot. The bench reaches the latch through an undervoltage episode in which the overtemperature error stays hidden, and then steps the enable-low pulse width and the cooled flag on each side of the limit. A second hard case is overvoltage striking while the low side conducts with the slowest slew setting selected. The bench measures the gap at the gates there to show that the dead interval drops to the fastest value.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
  typedef enum logic [2:0] {
    MODE_STBY = 3'd0,
    MODE_LS   = 3'd1,
    MODE_HS   = 3'd2,
    MODE_OV   = 3'd3,
    MODE_UV   = 3'd4,
    MODE_OT   = 3'd5
  } hb_mode_e;

  localparam int unsigned SUP_N  = 2;
  localparam int unsigned SUP_OV = 0;
  localparam int unsigned SUP_UV = 1;
endpackage

// File: rtl/hb_hyst_flag.sv
module hb_hyst_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic exit_i,
  output logic active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      active_o <= 1'b0;
    else if (enter_i) active_o <= 1'b1;
    else if (exit_i)  active_o <= 1'b0;
  end
endmodule

// File: rtl/hb_ot_latch.sv
module hb_ot_latch #(
  parameter int unsigned RST_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inh_i,
  input  logic ot_i,
  input  logic cool_i,
  output logic latched_o
);
  localparam int unsigned CNT_W = (RST_CYC > 2) ? $clog2(RST_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYC - 1);

  logic [CNT_W-1:0] low_cnt;
  logic             clr;

  // counts consecutive inhibit-low edges, saturating one short of the limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                low_cnt <= '0;
    else if (inh_i)             low_cnt <= '0;
    else if (low_cnt != CNT_LAST) low_cnt <= low_cnt + 1'b1;
  end

  assign clr = !inh_i && (low_cnt == CNT_LAST) && cool_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   latched_o <= 1'b0;
    else if (ot_i) latched_o <= 1'b1;
    else if (clr)  latched_o <= 1'b0;
  end
endmodule

// File: rtl/hb_mode_dec.sv
module hb_mode_dec
  import hb_gate_pkg::*;
(
  input  logic     ov_i,
  input  logic     uv_i,
  input  logic     ot_i,
  input  logic     inh_i,
  input  logic     dir_i,
  output hb_mode_e mode_o,
  output logic     req_hs_o,
  output logic     req_ls_o,
  output logic     err_o,
  output logic     fault_o
);
  always_comb begin
    if (ov_i)        mode_o = MODE_OV;
    else if (uv_i)   mode_o = MODE_UV;
    else if (ot_i)   mode_o = MODE_OT;
    else if (!inh_i) mode_o = MODE_STBY;
    else if (dir_i)  mode_o = MODE_HS;
    else             mode_o = MODE_LS;
  end

  always_comb begin
    req_hs_o = 1'b0;
    req_ls_o = 1'b0;
    err_o    = 1'b0;
    fault_o  = 1'b0;
    unique case (mode_o)
      MODE_OV: begin req_hs_o = 1'b1; err_o = 1'b1; fault_o = 1'b1; end
      MODE_UV: fault_o = 1'b1;
      MODE_OT: begin err_o = inh_i; fault_o = 1'b1; end
      MODE_HS: req_hs_o = 1'b1;
      MODE_LS: req_ls_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/hb_dead_time.sv
module hb_dead_time #(
  parameter int unsigned DT_BASE = 2,
  parameter int unsigned SLEW_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_hs_i,
  input  logic              req_ls_i,
  input  logic [SLEW_W-1:0] sel_i,
  output logic              hs_o,
  output logic              ls_o
);
  localparam int unsigned SEL_N  = 1 << SLEW_W;
  localparam int unsigned DT_MAX = DT_BASE * SEL_N;
  localparam int unsigned CNT_W  = $clog2(DT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(DT_MAX);

  logic [CNT_W-1:0] dt_tab [SEL_N];
  logic [CNT_W-1:0] off_cnt;
  logic             gap_ok;

  for (genvar g = 0; g < SEL_N; g++) begin : g_dt
    assign dt_tab[g] = CNT_W'(DT_BASE * (g + 1));
  end

  // cycles since both gates went low; starts saturated out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               off_cnt <= CNT_SAT;
    else if (hs_o || ls_o)     off_cnt <= '0;
    else if (off_cnt != CNT_SAT) off_cnt <= off_cnt + 1'b1;
  end

  assign gap_ok = off_cnt >= dt_tab[sel_i];

  // turn-off is immediate, turn-on waits for the other side and the gap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_o <= 1'b0;
      ls_o <= 1'b0;
    end else begin
      hs_o <= req_hs_i && (hs_o || (!ls_o && gap_ok));
      ls_o <= req_ls_i && !req_hs_i && (ls_o || (!hs_o && gap_ok));
    end
  end
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_gate_pkg::*;
#(
  parameter int unsigned DT_BASE = 2,
  parameter int unsigned SLEW_W  = 2,
  parameter int unsigned RST_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_i,
  input  logic              inh_i,
  input  logic              ov_enter_i,
  input  logic              ov_exit_i,
  input  logic              uv_enter_i,
  input  logic              uv_exit_i,
  input  logic              ot_i,
  input  logic              ot_cool_i,
  input  logic [SLEW_W-1:0] slew_sel_i,
  output logic              hs_en_o,
  output logic              ls_en_o,
  output logic              err_o,
  output logic              sense_mode_o,
  output logic              fast_slew_o
);
  logic [SUP_N-1:0] sup_enter, sup_exit, sup_act;
  logic             ov_act, uv_act, ot_act;
  logic             req_hs, req_ls, fault;
  logic [SLEW_W-1:0] eff_sel;
  hb_mode_e         mode;

  assign sup_enter[SUP_OV] = ov_enter_i;
  assign sup_exit [SUP_OV] = ov_exit_i;
  assign sup_enter[SUP_UV] = uv_enter_i;
  assign sup_exit [SUP_UV] = uv_exit_i;

  for (genvar s = 0; s < SUP_N; s++) begin : g_sup
    hb_hyst_flag u_hyst (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .enter_i  (sup_enter[s]),
      .exit_i   (sup_exit[s]),
      .active_o (sup_act[s])
    );
  end

  assign ov_act = sup_act[SUP_OV];
  assign uv_act = sup_act[SUP_UV];

  hb_ot_latch #(.RST_CYC(RST_CYC)) u_ot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inh_i     (inh_i),
    .ot_i      (ot_i),
    .cool_i    (ot_cool_i),
    .latched_o (ot_act)
  );

  hb_mode_dec u_dec (
    .ov_i     (ov_act),
    .uv_i     (uv_act),
    .ot_i     (ot_act),
    .inh_i    (inh_i),
    .dir_i    (dir_i),
    .mode_o   (mode),
    .req_hs_o (req_hs),
    .req_ls_o (req_ls),
    .err_o    (err_o),
    .fault_o  (fault)
  );

  // faults run at the fastest slew, hence the shortest gap
  assign eff_sel = fault ? '0 : slew_sel_i;

  hb_dead_time #(.DT_BASE(DT_BASE), .SLEW_W(SLEW_W)) u_dt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_hs_i (req_hs),
    .req_ls_i (req_ls),
    .sel_i    (eff_sel),
    .hs_o     (hs_en_o),
    .ls_o     (ls_en_o)
  );

  assign fast_slew_o  = fault;
  assign sense_mode_o = (mode == MODE_HS) && hs_en_o;
endmodule

// File: rtl/hb_gate_chk.sv
module hb_gate_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic inh_i,
  input logic hs_en_o,
  input logic ls_en_o,
  input logic err_o,
  input logic sense_mode_o,
  input logic fast_slew_o,
  input logic ov_act,
  input logic uv_act,
  input logic ot_act
);
  AST_GATE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_o && ls_en_o));                                            // R8
  AST_STBY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inh_i && !fast_slew_o) |=> (!hs_en_o && !ls_en_o));              // R1
  AST_OV_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_act |-> err_o);                                                 // R3
  AST_OV_LS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_act |=> !ls_en_o);                                              // R3
  AST_UV_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_act && !ov_act) |=> (!hs_en_o && !ls_en_o));                   // R4
  AST_UV_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_act && !ov_act) |-> !err_o);                                   // R4
  AST_OT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ot_act) |-> !$past(inh_i));                                  // R6
  AST_ERR_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> fast_slew_o);                                            // R7
  AST_LS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_en_o) |-> !$past(hs_en_o));                               // R9
  AST_HS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> !$past(ls_en_o));                               // R9
  AST_SENSE_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_mode_o |-> (hs_en_o && !err_o && !fast_slew_o));             // R10
endmodule

bind hb_gate_ctrl hb_gate_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .inh_i        (inh_i),
  .hs_en_o      (hs_en_o),
  .ls_en_o      (ls_en_o),
  .err_o        (err_o),
  .sense_mode_o (sense_mode_o),
  .fast_slew_o  (fast_slew_o),
  .ov_act       (ov_act),
  .uv_act       (uv_act),
  .ot_act       (ot_act)
);

// File: tb/sim_hb_gate_ctrl.sv
`timescale 1ns/1ps
module sim_hb_gate_ctrl;
  localparam int unsigned DT_BASE = 2;
  localparam int unsigned SLEW_W  = 2;
  localparam int unsigned RST_CYC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir = 1'b0, inh = 1'b0;
  logic ov_en = 1'b0, ov_ex = 1'b0, uv_en = 1'b0, uv_ex = 1'b0;
  logic ot = 1'b0, cool = 1'b0;
  logic [SLEW_W-1:0] sel = '0;
  logic hs, ls, err, sense, fast;

  int checks = 0;
  int errors = 0;
  int overlaps = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hb_gate_ctrl #(.DT_BASE(DT_BASE), .SLEW_W(SLEW_W), .RST_CYC(RST_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .dir_i(dir), .inh_i(inh),
    .ov_enter_i(ov_en), .ov_exit_i(ov_ex), .uv_enter_i(uv_en), .uv_exit_i(uv_ex),
    .ot_i(ot), .ot_cool_i(cool), .slew_sel_i(sel),
    .hs_en_o(hs), .ls_en_o(ls), .err_o(err), .sense_mode_o(sense), .fast_slew_o(fast)
  );

  // R8: gates never both on, watched every cycle
  always @(negedge clk) if (rst_n && hs && ls) overlaps++;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int e_hs, input int e_ls,
                         input int e_err, input int e_sense, input int e_fast);
    chk({req, " hs"}, int'(hs), e_hs);
    chk({req, " ls"}, int'(ls), e_ls);
    chk({req, " err"}, int'(err), e_err);
    chk({req, " sense"}, int'(sense), e_sense);
    chk({req, " fast"}, int'(fast), e_fast);
  endtask

  // cycles with both gates low between one conduction phase and the next
  task automatic measure_gap(output int n);
    n = 0;
    for (int i = 0; i < 20 && (hs || ls); i++) step(1);
    for (int i = 0; i < 40 && !hs && !ls; i++) begin
      n++;
      step(1);
    end
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    step(1);
    sig = 1'b0;
  endtask

  task automatic t_reset();
    chk_out("R1 reset", 0, 0, 0, 0, 0);
    dir = 1'b1;
    step(3);
    chk_out("R1 standby dir1", 0, 0, 0, 0, 0);
    dir = 1'b0;
    step(3);
    chk_out("R1 standby dir0", 0, 0, 0, 0, 0);
  endtask

  task automatic t_normal();
    int gap;
    inh = 1'b1; dir = 1'b1; sel = 2'd0;
    step(3);
    chk_out("R2 R10 high side", 1, 0, 0, 1, 0);
    dir = 1'b0;
    measure_gap(gap);
    chk("R9 gap sel0", gap, DT_BASE * 1 + 1);
    step(1);
    chk_out("R2 R10 low side", 0, 1, 0, 0, 0);
    sel = 2'd3; dir = 1'b1;
    measure_gap(gap);
    chk("R9 gap sel3", gap, DT_BASE * 4 + 1);
    step(1);
    chk_out("R2 high side again", 1, 0, 0, 1, 0);
  endtask

  task automatic t_ov();
    int gap;
    dir = 1'b0; sel = 2'd3;
    step(12);
    chk_out("R2 low side before ov", 0, 1, 0, 0, 0);
    pulse(ov_en);
    measure_gap(gap);
    chk("R7 ov gap fastest", gap, DT_BASE * 1 + 1);
    step(1);
    chk_out("R3 R11 ov held", 1, 0, 1, 0, 1);
    inh = 1'b0;
    pulse(uv_en);
    step(3);
    chk_out("R3 ov over uv and inhibit", 1, 0, 1, 0, 1);
    pulse(ov_ex);
    step(3);
    chk_out("R4 uv after ov exit", 0, 0, 0, 0, 1);
    pulse(uv_ex);
    step(3);
    chk_out("R11 R1 exit to standby", 0, 0, 0, 0, 0);
    ov_en = 1'b1; ov_ex = 1'b1;
    step(1);
    ov_en = 1'b0; ov_ex = 1'b0;
    step(12);
    chk_out("R11 enter wins", 1, 0, 1, 0, 1);
    pulse(ov_ex);
    step(3);
    chk_out("R11 ov exit", 0, 0, 0, 0, 0);
  endtask

  task automatic t_uv_ot();
    inh = 1'b1; dir = 1'b1; sel = 2'd0;
    step(12);
    chk_out("R2 hs before uv", 1, 0, 0, 1, 0);
    pulse(uv_en);
    step(3);
    chk_out("R4 R11 uv held", 0, 0, 0, 0, 1);
    pulse(ot);
    step(3);
    chk_out("R4 uv masks ot", 0, 0, 0, 0, 1);
    pulse(uv_ex);
    step(3);
    chk_out("R5 ot latched inh high", 0, 0, 1, 0, 1);
    inh = 1'b0;
    step(2);
    chk_out("R5 ot latched inh low", 0, 0, 0, 0, 1);
    // short inhibit pulse, cooled
    inh = 1'b1; cool = 1'b1;
    step(2);
    inh = 1'b0;
    step(RST_CYC - 1);
    inh = 1'b1;
    step(3);
    chk_out("R6 short pulse keeps latch", 0, 0, 1, 0, 1);
    // long pulse, still hot
    cool = 1'b0;
    inh = 1'b0;
    step(RST_CYC + 2);
    inh = 1'b1;
    step(3);
    chk_out("R6 hot keeps latch", 0, 0, 1, 0, 1);
    // exact-length pulse, cooled
    cool = 1'b1;
    inh = 1'b0;
    step(RST_CYC);
    inh = 1'b1;
    step(12);
    chk_out("R6 R7 latch cleared", 1, 0, 0, 1, 0);
    cool = 1'b0;
  endtask

  task automatic t_ot_direct();
    dir = 1'b0;
    step(12);
    chk_out("R2 ls before ot", 0, 1, 0, 0, 0);
    pulse(ot);
    step(2);
    chk_out("R5 ot turns off", 0, 0, 1, 0, 1);
    dir = 1'b1;
    step(5);
    chk_out("R5 dir ignored under ot", 0, 0, 1, 0, 1);
    cool = 1'b1; inh = 1'b0;
    step(RST_CYC + 1);
    inh = 1'b1;
    step(12);
    chk_out("R6 cleared again", 1, 0, 0, 1, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_normal();
    t_ov();
    t_uv_ot();
    t_ot_direct();
    chk("R8 overlap cycles", overlaps, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule